// File: doc/BRIEF.md
# Configurable DDR and SerDes I/O Register Cell

This block is the register path of one general-purpose I/O cell. It sits between the core logic and a pad. In the transmit direction it takes a 4-bit word from the core and drives the pad in one of three ways. In plain mode it sends one bit per slow clock. In double-rate mode it sends two bits per slow clock, one in each half-period. In serial mode it sends four bits per slow clock, one per fast clock period. In the receive direction it does the reverse and returns one, two or four pad samples per slow clock on a 4-bit core bus.

Each direction has its own slow clock and its own fast clock. Each fast clock runs at four times its slow clock and has a rising edge at every slow rising edge. The pad enable can be taken from a slow-clock register or passed straight through. A differential option copies the enable onto a second, complementary enable output. The pad is modelled as three separate wires: data in, data out and enable.

Mode codes used on both mode inputs: 0 = plain, 1 = double-rate, 2 = serial, 3 = plain.

Top module: `iocell_ddr_serdes`

## Requirements
- R1: While `rst` is high (synchronous, active high), `pad_oe` and `pad_oe_n` are 0. After the next rising edge of each clock in reset, `core_din` is all zeros and `pad_out` is 0.
- R2: With `out_mode` = 0, each `out_clk` rising edge registers `core_dout`. `pad_out` then equals bit 0 of that word for the whole slow period. Bits 3..1 have no effect on the pad.
- R3: With `out_mode` = 1, a word registered at an `out_clk` rising edge drives bit 0 while `out_clk` is high and bit 1 while `out_clk` is low.
- R4: With `out_mode` = 2, a word registered at `out_clk` rising edge E is sent least significant bit first. Bit k is on `pad_out` from fast edge E+k+1 until fast edge E+k+2.
- R5: With `in_mode` = 0, each `in_clk` rising edge sets `core_din` bit 0 to the `pad_in` value sampled at that edge. Bits 3..1 are set to 0.
- R6: With `in_mode` = 1, at `in_clk` rising edge k+1 `core_din` becomes {0, 0, f, r}. Here r is `pad_in` sampled at rising edge k and f is `pad_in` sampled at the falling edge that follows it.
- R7: With `in_mode` = 2, at each `in_clk` rising edge `core_din` takes the four `pad_in` samples from the four `in_fclk` rising edges of the previous slow period. The sample from the edge that coincides with the previous slow edge goes to bit 0; later samples go to bits 1, 2 and 3.
- R8: With `oe_reg_en` = 1, `pad_oe` is `core_oe` registered on `out_clk`. With `oe_reg_en` = 0, `pad_oe` follows `core_oe` with no clock delay.
- R9: With `diff_en` = 1, `pad_oe_n` equals `pad_oe`. With `diff_en` = 0, `pad_oe_n` is 0.
- R10: Mode code 3 behaves as mode 0 in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| out_clk | input | 1 | Slow transmit clock: data and enable registers |
| out_fclk | input | 1 | Fast transmit clock (4x): serializer |
| in_clk | input | 1 | Slow receive clock: input register |
| in_fclk | input | 1 | Fast receive clock (4x): deserializer |
| rst | input | 1 | Synchronous reset, active high |
| out_mode | input | 2 | Transmit mode code |
| in_mode | input | 2 | Receive mode code |
| oe_reg_en | input | 1 | 1 = registered enable, 0 = pass-through |
| diff_en | input | 1 | Differential: mirror enable onto `pad_oe_n` |
| core_oe | input | 1 | Enable from core |
| core_dout | input | RATIO | Word from core to pad |
| core_din | output | RATIO | Word from pad to core |
| pad_out | output | 1 | Pad data out |
| pad_oe | output | 1 | Pad enable |
| pad_oe_n | output | 1 | Complementary pad enable |
| pad_in | input | 1 | Pad data in |

## Verification
The bench changes every input 2 ns after a slow rising edge, and for fast-rate stimulus at mid fast period, so that no input changes at a clock edge. Plain and double-rate transmit results appear one slow edge after the word is driven. The high-half bit is sampled 2 ns after that edge and the low-half bit 2 ns after the falling edge. Serial bit k of a word registered at edge E is sampled 10 + 8k ns after E, so bit 3 is read just after the next slow edge. Plain receive data appears at the slow edge after the sample. Double-rate and serial receive words appear one slow period after their first sample. The bench pairs each word it reads with the stimulus of the matching earlier period and skips the first period after each mode change.

// File: rtl/iocell_pkg.sv
`timescale 1ns/1ps
package iocell_pkg;

   typedef enum logic [1:0] {
      MODE_SDR = 2'd0,
      MODE_DDR = 2'd1,
      MODE_SER = 2'd2,
      MODE_RSV = 2'd3
   } io_mode_e;

   // Reserved code folds onto plain single-rate behaviour.
   function automatic io_mode_e norm_mode(input logic [1:0] code);
      io_mode_e m;
      case (code)
         2'd1:    m = MODE_DDR;
         2'd2:    m = MODE_SER;
         default: m = MODE_SDR;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/iocell_oe.sv
`timescale 1ns/1ps
module iocell_oe #(
   parameter bit HAS_DIFF = 1'b1
) (
   input  logic sclk,
   input  logic rst,
   input  logic reg_en,
   input  logic diff_en,
   input  logic oe_in,
   output logic oe,
   output logic oe_n
);

   logic oe_q;

   always_ff @(posedge sclk) begin
      if (rst) oe_q <= 1'b0;
      else     oe_q <= oe_in;
   end

   // Reset holds the pad released even in pass-through.
   always_comb begin
      if (rst)         oe = 1'b0;
      else if (reg_en) oe = oe_q;
      else             oe = oe_in;
   end

   generate
      if (HAS_DIFF) begin : g_diff
         assign oe_n = diff_en & oe;
      end else begin : g_single
         logic unused_diff;
         assign unused_diff = diff_en;
         assign oe_n = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/iocell_tx.sv
`timescale 1ns/1ps
module iocell_tx
   import iocell_pkg::*;
#(
   parameter int RATIO = 4
) (
   input  logic             sclk,
   input  logic             fclk,
   input  logic             rst,
   input  io_mode_e         mode,
   input  logic [RATIO-1:0] dout,
   output logic             pad_o
);

   logic [RATIO-1:0] word_q;
   logic [RATIO-1:0] sh_q;
   logic             tgl_q;
   logic             tgl_seen_q;
   logic             load;

   // Slow domain: parallel word plus a marker toggled on every slow edge.
   always_ff @(posedge sclk) begin
      if (rst) begin
         word_q <= '0;
         tgl_q  <= 1'b0;
      end else begin
         word_q <= dout;
         tgl_q  <= ~tgl_q;
      end
   end

   // Fast domain sees the toggle one fast edge after the slow edge.
   assign load = tgl_q ^ tgl_seen_q;

   always_ff @(posedge fclk) begin
      if (rst) begin
         sh_q       <= '0;
         tgl_seen_q <= 1'b0;
      end else begin
         tgl_seen_q <= tgl_q;
         if (load) sh_q <= word_q;
         else      sh_q <= sh_q >> 1;
      end
   end

   always_comb begin
      case (mode)
         MODE_DDR: pad_o = sclk ? word_q[0] : word_q[1];
         MODE_SER: pad_o = sh_q[0];
         default:  pad_o = word_q[0];
      endcase
   end

endmodule

// File: rtl/iocell_rx.sv
`timescale 1ns/1ps
module iocell_rx
   import iocell_pkg::*;
#(
   parameter int RATIO = 4
) (
   input  logic             sclk,
   input  logic             fclk,
   input  logic             rst,
   input  io_mode_e         mode,
   input  logic             pad_i,
   output logic [RATIO-1:0] din
);

   logic             rise_q;
   logic             fall_q;
   logic [RATIO-1:0] dsh_q;
   logic [RATIO-1:0] din_q;

   always_ff @(negedge sclk) begin
      if (rst) fall_q <= 1'b0;
      else     fall_q <= pad_i;
   end

   // First received bit travels down to bit 0 after RATIO shifts.
   always_ff @(posedge fclk) begin
      if (rst) dsh_q <= '0;
      else     dsh_q <= {pad_i, dsh_q[RATIO-1:1]};
   end

   always_ff @(posedge sclk) begin
      if (rst) begin
         rise_q <= 1'b0;
         din_q  <= '0;
      end else begin
         rise_q <= pad_i;
         case (mode)
            MODE_DDR: din_q <= RATIO'({fall_q, rise_q});
            MODE_SER: din_q <= dsh_q;
            default:  din_q <= RATIO'(pad_i);
         endcase
      end
   end

   assign din = din_q;

endmodule

// File: rtl/iocell_ddr_serdes.sv
`timescale 1ns/1ps
module iocell_ddr_serdes
   import iocell_pkg::*;
#(
   parameter int RATIO    = 4,
   parameter bit HAS_DIFF = 1'b1
) (
   input  logic             out_clk,
   input  logic             out_fclk,
   input  logic             in_clk,
   input  logic             in_fclk,
   input  logic             rst,
   input  logic [1:0]       out_mode,
   input  logic [1:0]       in_mode,
   input  logic             oe_reg_en,
   input  logic             diff_en,
   input  logic             core_oe,
   input  logic [RATIO-1:0] core_dout,
   output logic [RATIO-1:0] core_din,
   output logic             pad_out,
   output logic             pad_oe,
   output logic             pad_oe_n,
   input  logic             pad_in
);

   generate
      if (RATIO < 2 || RATIO > 16) begin : g_bad_ratio
         $error("iocell_ddr_serdes: RATIO must lie in 2..16");
      end
   endgenerate

   io_mode_e tx_mode;
   io_mode_e rx_mode;

   assign tx_mode = norm_mode(out_mode);
   assign rx_mode = norm_mode(in_mode);

   iocell_tx #(.RATIO(RATIO)) u_tx (
      .sclk  (out_clk),
      .fclk  (out_fclk),
      .rst   (rst),
      .mode  (tx_mode),
      .dout  (core_dout),
      .pad_o (pad_out)
   );

   iocell_rx #(.RATIO(RATIO)) u_rx (
      .sclk  (in_clk),
      .fclk  (in_fclk),
      .rst   (rst),
      .mode  (rx_mode),
      .pad_i (pad_in),
      .din   (core_din)
   );

   iocell_oe #(.HAS_DIFF(HAS_DIFF)) u_oe (
      .sclk    (out_clk),
      .rst     (rst),
      .reg_en  (oe_reg_en),
      .diff_en (diff_en),
      .oe_in   (core_oe),
      .oe      (pad_oe),
      .oe_n    (pad_oe_n)
   );

endmodule

// File: rtl/iocell_ddr_serdes_chk.sv
`timescale 1ns/1ps
module iocell_ddr_serdes_chk #(
   parameter int RATIO    = 4,
   parameter bit HAS_DIFF = 1'b1
) (
   input logic             out_clk,
   input logic             out_fclk,
   input logic             in_clk,
   input logic             rst,
   input logic [1:0]       out_mode,
   input logic [1:0]       in_mode,
   input logic             oe_reg_en,
   input logic             diff_en,
   input logic             core_oe,
   input logic             core_dout0,
   input logic [RATIO-1:0] core_din,
   input logic             pad_out,
   input logic             pad_oe,
   input logic             pad_oe_n,
   input logic             pad_in
);

   // R1: enable released throughout reset
   a_r1_oe_low_in_reset: assert property (@(posedge out_clk)
      rst |-> !pad_oe);

   // R8: registered enable lags the core enable by one slow edge
   a_r8_oe_registered: assert property (@(posedge out_clk) disable iff (rst)
      (oe_reg_en && $past(oe_reg_en) && !$past(rst)) |-> pad_oe == $past(core_oe));

   // R2: plain transmit carries bit 0 of the previous word
   a_r2_sdr_out: assert property (@(posedge out_clk) disable iff (rst)
      (out_mode == 2'd0 && $past(out_mode) == 2'd0 && !$past(rst))
      |-> pad_out == $past(core_dout0));

   // R9: complementary enable mirrors only in differential mode
   a_r9_oe_n_mirror: assert property (@(posedge out_fclk) disable iff (rst)
      pad_oe_n == (HAS_DIFF && diff_en && pad_oe));

   // R5: plain receive returns the pad value of the previous edge
   a_r5_sdr_in: assert property (@(posedge in_clk) disable iff (rst)
      (in_mode == 2'd0 && $past(in_mode) == 2'd0 && !$past(rst))
      |-> core_din == RATIO'($past(pad_in)));

   // R6: double-rate receive leaves upper lanes at zero
   a_r6_ddr_upper_zero: assert property (@(posedge in_clk) disable iff (rst)
      (in_mode == 2'd1 && $past(in_mode) == 2'd1 && !$past(rst))
      |-> core_din[RATIO-1:2] == '0);

endmodule

bind iocell_ddr_serdes iocell_ddr_serdes_chk #(.RATIO(RATIO), .HAS_DIFF(HAS_DIFF)) u_chk (
   .out_clk    (out_clk),
   .out_fclk   (out_fclk),
   .in_clk     (in_clk),
   .rst        (rst),
   .out_mode   (out_mode),
   .in_mode    (in_mode),
   .oe_reg_en  (oe_reg_en),
   .diff_en    (diff_en),
   .core_oe    (core_oe),
   .core_dout0 (core_dout[0]),
   .core_din   (core_din),
   .pad_out    (pad_out),
   .pad_oe     (pad_oe),
   .pad_oe_n   (pad_oe_n),
   .pad_in     (pad_in)
);

// File: tb/iocell_ddr_serdes_test.sv
`timescale 1ns/1ps
module iocell_ddr_serdes_test;

   logic       fclk = 1'b0;
   logic       sclk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] out_mode = 2'd0;
   logic [1:0] in_mode = 2'd0;
   logic       oe_reg_en = 1'b1;
   logic       diff_en = 1'b1;
   logic       core_oe = 1'b1;
   logic [3:0] core_dout = 4'hF;
   logic [3:0] core_din;
   logic       pad_out;
   logic       pad_oe;
   logic       pad_oe_n;
   logic       pad_in = 1'b1;

   int total = 0;
   int bad = 0;

   iocell_ddr_serdes uut (
      .out_clk   (sclk),
      .out_fclk  (fclk),
      .in_clk    (sclk),
      .in_fclk   (fclk),
      .rst       (rst),
      .out_mode  (out_mode),
      .in_mode   (in_mode),
      .oe_reg_en (oe_reg_en),
      .diff_en   (diff_en),
      .core_oe   (core_oe),
      .core_dout (core_dout),
      .core_din  (core_din),
      .pad_out   (pad_out),
      .pad_oe    (pad_oe),
      .pad_oe_n  (pad_oe_n),
      .pad_in    (pad_in)
   );

   // 125 MHz fast clock; slow clock at a quarter rate, rising with it.
   initial forever begin #4 fclk = 1'b1; #4 fclk = 1'b0; end
   initial forever begin #4 sclk = 1'b1; #16 sclk = 1'b0; #12; end

   task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] sdr_in_word(input logic p);
      return {3'b000, p};
   endfunction

   function automatic logic [3:0] ddr_in_word(input logic r, input logic f);
      return {2'b00, f, r};
   endfunction

   task automatic run_all();
      logic [3:0] prev;
      logic [3:0] w [0:9];
      logic [3:0] gw [0:10];
      logic       a [0:8];
      logic       b [0:8];
      logic       p_prev;
      logic       p;
      prev = '0;
      p_prev = 1'b0;

      // R1: reset state
      repeat (3) @(posedge sclk);
      #2;
      chk("R1 pad_oe", {3'b0, pad_oe}, 4'h0);
      chk("R1 pad_oe_n", {3'b0, pad_oe_n}, 4'h0);
      chk("R1 core_din", core_din, 4'h0);
      chk("R1 pad_out", {3'b0, pad_out}, 4'h0);
      rst = 1'b0;

      // R2 / R10: plain transmit, then with reserved code
      for (int m = 0; m < 2; m++) begin
         out_mode = (m == 0) ? 2'd0 : 2'd3;
         for (int i = 0; i < 8; i++) begin
            logic [3:0] nw;
            @(posedge sclk); #2;
            if (i > 0) chk(m == 0 ? "R2 high" : "R10 out high", {3'b0, pad_out}, {3'b0, prev[0]});
            nw = (i == 1) ? 4'b1110 : (i == 2) ? 4'b0001 : 4'($urandom);
            core_dout = nw;
            #16;
            if (i > 0) chk(m == 0 ? "R2 low" : "R10 out low", {3'b0, pad_out}, {3'b0, prev[0]});
            prev = nw;
         end
      end

      // R3: double-rate transmit
      out_mode = 2'd1;
      for (int i = 0; i < 10; i++) begin
         logic [3:0] nw;
         @(posedge sclk); #2;
         if (i > 0) chk("R3 rise half", {3'b0, pad_out}, {3'b0, prev[0]});
         nw = (i == 0) ? 4'b0001 : (i == 1) ? 4'b0010 : 4'($urandom);
         core_dout = nw;
         #16;
         if (i > 0) chk("R3 fall half", {3'b0, pad_out}, {3'b0, prev[1]});
         prev = nw;
      end

      // R4: serializer, bit 0 first
      out_mode = 2'd2;
      for (int i = 0; i < 10; i++) begin
         @(posedge sclk); #2;
         if (i >= 2) chk("R4 bit3", {3'b0, pad_out}, {3'b0, w[i-2][3]});
         w[i] = (i == 0) ? 4'b0001 : (i == 1) ? 4'b1000 : 4'($urandom);
         core_dout = w[i];
         #8;
         if (i >= 1) chk("R4 bit0", {3'b0, pad_out}, {3'b0, w[i-1][0]});
         #8;
         if (i >= 1) chk("R4 bit1", {3'b0, pad_out}, {3'b0, w[i-1][1]});
         #8;
         if (i >= 1) chk("R4 bit2", {3'b0, pad_out}, {3'b0, w[i-1][2]});
      end

      // R5 / R10: plain receive
      for (int m = 0; m < 2; m++) begin
         in_mode = (m == 0) ? 2'd0 : 2'd3;
         for (int i = 0; i < 8; i++) begin
            @(posedge sclk); #2;
            if (i > 0) chk(m == 0 ? "R5 plain in" : "R10 in", core_din, sdr_in_word(p_prev));
            p = (i == 1) ? 1'b1 : (i == 2) ? 1'b0 : 1'($urandom);
            pad_in = p;
            p_prev = p;
         end
      end

      // R6: double-rate receive
      in_mode = 2'd1;
      a[0] = 1'b1;
      pad_in = a[0];
      for (int i = 0; i < 8; i++) begin
         @(posedge sclk); #2;
         if (i > 0) chk("R6 ddr in", core_din, ddr_in_word(a[i-1], b[i-1]));
         #8;
         b[i] = (i == 0) ? 1'b0 : (i == 1) ? 1'b1 : 1'($urandom);
         pad_in = b[i];
         #16;
         a[i+1] = (i == 0) ? 1'b0 : 1'($urandom);
         pad_in = a[i+1];
      end

      // R7: deserializer, first bit lands in bit 0
      in_mode = 2'd2;
      @(posedge sclk); #28;
      gw[0] = 4'b0001;
      pad_in = gw[0][0];
      for (int i = 0; i < 10; i++) begin
         @(posedge sclk); #2;
         if (i >= 1) chk("R7 deser", core_din, gw[i-1]);
         #2;  pad_in = gw[i][1];
         #8;  pad_in = gw[i][2];
         #8;  pad_in = gw[i][3];
         gw[i+1] = (i == 0) ? 4'b1000 : 4'($urandom);
         #8;  pad_in = gw[i+1][0];
      end

      // R8 / R9: enable handling
      oe_reg_en = 1'b1;
      diff_en = 1'b1;
      @(posedge sclk); #2;
      core_oe = 1'b0;
      #1;
      chk("R8 registered holds", {3'b0, pad_oe}, 4'h1);
      @(posedge sclk); #2;
      chk("R8 registered update", {3'b0, pad_oe}, 4'h0);
      chk("R9 mirror low", {3'b0, pad_oe_n}, 4'h0);
      core_oe = 1'b1;
      @(posedge sclk); #2;
      chk("R8 registered high", {3'b0, pad_oe}, 4'h1);
      chk("R9 mirror high", {3'b0, pad_oe_n}, 4'h1);
      diff_en = 1'b0;
      #1;
      chk("R9 single-ended", {3'b0, pad_oe_n}, 4'h0);
      oe_reg_en = 1'b0;
      for (int i = 0; i < 6; i++) begin
         logic e;
         e = (i == 0) ? 1'b0 : 1'($urandom);
         core_oe = e;
         #3;
         chk("R8 pass-through", {3'b0, pad_oe}, {3'b0, e});
      end

      // R1: reset mid-run
      core_oe = 1'b1;
      diff_en = 1'b1;
      @(posedge sclk); #2;
      rst = 1'b1;
      #1;
      chk("R1 oe forced low", {3'b0, pad_oe}, 4'h0);
      chk("R1 oe_n forced low", {3'b0, pad_oe_n}, 4'h0);
      @(posedge sclk); #2;
      chk("R1 din cleared", core_din, 4'h0);
      chk("R1 pad_out cleared", {3'b0, pad_out}, 4'h0);
   endtask

   initial begin
      void'($urandom(32'd1234));
      run_all();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #1_000_000;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule